// File: doc/BRIEF.md
# I2C Master SCL Half-Period Timer

This block times the low and high halves of the SCL clock for an I2C bus master. A master sequencer sends a one-cycle request that starts a low half. The block loads a 7-bit reload value, drives SCL low, and counts down to zero. Each count step happens on one of two quarter-phase strobes per instruction cycle. At zero the counter stops and SCL is released.

A slave can stretch the clock by holding the line low. While it does, the count stays at zero and no reload takes place. The high half starts only once the synchronized line is actually seen high: the block then reloads and counts down a second time. When the high half reaches zero the block goes idle with SCL released and waits for the next request. A terminal-count flag tells the sequencer when each half has ended.

Top module: `scl_period_timer`

## Requirements
- R1: After reset the count is 0, the terminal-count flag `tc` is 1 and SCL is released (`scl_rel` = 1).
- R2: A one-cycle `load_req` pulse makes the count equal `reload_val` in the next cycle and drives SCL low (`scl_rel` = 0).
- R3: The count steps down by exactly one on each of the two quarter strobes per four-clock instruction cycle (quarters 1 and 3 after reset). Going from N to 0 therefore takes 2N-1 or 2N clocks.
- R4: In the low half the counter stops at 0 and does not wrap, and SCL is released on the clock after the count first reads 0.
- R5: While SCL is released but the line is held low, the count stays at 0 and `tc` stays 1.
- R6: The reload for the high half occurs on the third clock edge after the line rises, because the line passes through a two-flop synchronizer. The line must first have been seen low after the low half started.
- R7: A reload value of 0 gives `tc` = 1 at once, and the count never takes a value above the last loaded value.
- R8: When the high half reaches 0 the count stays at 0 and SCL stays released, and nothing reloads until the next `load_req`.
- R9: `reload_val` is sampled only at the moment of a reload. Changes between reloads do not alter the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload_val | input | 7 | Half-period reload value |
| load_req | input | 1 | One-cycle request to start a low half |
| scl_in | input | 1 | Observed SCL line level |
| count | output | 7 | Current down-counter value |
| tc | output | 1 | Terminal count, high while count is 0 |
| scl_rel | output | 1 | 1 = release SCL, 0 = drive SCL low |

## Verification
The bench builds the block with its defaults: a 7-bit count, a two-stage synchronizer and four quarters per instruction cycle. With these defaults the largest reload of 127 fits in about 254 clocks per half, so the full range, including the stop at zero, is exercised directly. The defaults also fix the reload latency after a stretch at exactly three edges, which lets the bench pin down the reload cycle and the zero-reload corner exactly.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;
   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_LOW  = 2'd1,
      HS_WAIT = 2'd2,
      HS_HIGH = 2'd3
   } half_state_e;
endpackage

// File: rtl/scl_qphase_gen.sv
module scl_qphase_gen #(
   parameter int QUARTERS = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic step_stb
);
   localparam int QW   = (QUARTERS > 1) ? $clog2(QUARTERS) : 1;
   localparam int PH_A = QUARTERS / 4;
   localparam int PH_B = (3 * QUARTERS) / 4;

   if (QUARTERS < 4 || (QUARTERS % 4) != 0) begin : g_bad_quarters
      $error("scl_qphase_gen: QUARTERS must be a multiple of 4");
   end

   logic [QW-1:0] quarter_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         quarter_q <= '0;
      else if (quarter_q == QW'(QUARTERS - 1))
         quarter_q <= '0;
      else
         quarter_q <= quarter_q + 1'b1;
   end

   assign step_stb = (quarter_q == QW'(PH_A)) || (quarter_q == QW'(PH_B));
endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("scl_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b1;
            else        chain_q[0] <= line_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign line_sync = chain_q[STAGES-1];
endmodule

// File: rtl/scl_half_counter.sv
module scl_half_counter #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             zero
);
   if (CNT_W < 1) begin : g_bad_width
      $error("scl_half_counter: CNT_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (dec && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/scl_period_timer.sv
module scl_period_timer #(
   parameter int CNT_W       = 7,
   parameter int SYNC_STAGES = 2,
   parameter int QUARTERS    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             load_req,
   input  logic             scl_in,
   output logic [CNT_W-1:0] count,
   output logic             tc,
   output logic             scl_rel
);
   import scl_timer_pkg::*;

   half_state_e state_q;
   logic        step_stb;
   logic        line_hi;
   logic        seen_low_q;
   logic        cnt_zero;
   logic        hi_reload;
   logic        cnt_load;
   logic        cnt_dec;

   scl_qphase_gen #(.QUARTERS(QUARTERS)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_stb (step_stb)
   );

   scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (scl_in),
      .line_sync (line_hi)
   );

   assign hi_reload = (state_q == HS_WAIT) && line_hi && seen_low_q && !load_req;
   assign cnt_load  = load_req || hi_reload;
   assign cnt_dec   = step_stb && (state_q == HS_LOW || state_q == HS_HIGH);

   scl_half_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (reload_val),
      .dec      (cnt_dec),
      .cnt      (count),
      .zero     (cnt_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= HS_IDLE;
         scl_rel    <= 1'b1;
         seen_low_q <= 1'b0;
      end else if (load_req) begin
         state_q    <= HS_LOW;
         scl_rel    <= 1'b0;
         seen_low_q <= 1'b0;
      end else begin
         unique case (state_q)
            HS_IDLE: ;
            HS_LOW: begin
               if (!line_hi) seen_low_q <= 1'b1;
               if (cnt_zero) begin
                  state_q <= HS_WAIT;
                  scl_rel <= 1'b1;
               end
            end
            HS_WAIT: begin
               if (!line_hi) seen_low_q <= 1'b1;
               if (hi_reload) state_q <= HS_HIGH;
            end
            HS_HIGH: begin
               if (cnt_zero) state_q <= HS_IDLE;
            end
            default: state_q <= HS_IDLE;
         endcase
      end
   end

   assign tc = cnt_zero;
endmodule

// File: rtl/scl_period_timer_chk.sv
module scl_period_timer_chk #(
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] reload_val,
   input logic             load_req,
   input logic             scl_in,
   input logic [CNT_W-1:0] count,
   input logic             scl_rel
);
   // R3: any fall of the count is a single step
   a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (count < $past(count)) |-> (count == $past(count) - 1'b1));

   // R7: the count rises only through a request or the high-half reload
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (count > $past(count)) |-> ($past(load_req) || $past(scl_rel)));

   // R2: a request loads the value and drives SCL low
   a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_req) |-> (count == $past(reload_val) && !scl_rel));

   // R4: SCL is driven low only because of a request
   a_r4_low_on_req: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_rel) |-> $past(load_req));

   // R5: a line held low keeps the released count at zero
   a_r5_hold_stretched: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(scl_rel) && $past(count) == '0 && !$past(load_req) && !$past(scl_in, 2))
      |-> (count == '0));
endmodule

bind scl_period_timer scl_period_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reload_val (reload_val),
   .load_req   (load_req),
   .scl_in     (scl_in),
   .count      (count),
   .scl_rel    (scl_rel)
);

// File: tb/tb_scl_period_timer.sv
module tb_scl_period_timer;
   localparam int W = 7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] reload_val = '0;
   logic         load_req = 1'b0;
   logic         slave_hold = 1'b0;
   logic         scl_in;
   logic [W-1:0] count;
   logic         tc;
   logic         scl_rel;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   assign scl_in = scl_rel & ~slave_hold;

   scl_period_timer dut (
      .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .load_req(load_req),
      .scl_in(scl_in), .count(count), .tc(tc), .scl_rel(scl_rel)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_load(input int n);
      @(negedge clk);
      reload_val = W'(n);
      load_req   = 1'b1;
      @(negedge clk);
      load_req   = 1'b0;
   endtask

   // low half: from just after load to the release cycle
   task automatic run_low(input int n);
      int edges = 0;
      int prev  = n;
      chk(count == W'(n), "R2 load value", int'(count), n);
      chk(scl_rel == 1'b0, "R2 scl driven low", int'(scl_rel), 0);
      while (count != 0 && edges < 400) begin
         @(negedge clk);
         edges++;
         if (int'(count) != prev) begin
            chk(int'(count) == prev - 1, "R3 single step", int'(count), prev - 1);
            prev = int'(count);
         end
      end
      if (n > 0)
         chk(edges == 2*n - 1 || edges == 2*n, "R3 low half length", edges, 2*n);
      chk(tc == 1'b1, "R4 tc at zero", int'(tc), 1);
      @(negedge clk);
      chk(scl_rel == 1'b1 && count == 0, "R4 release after zero", int'(scl_rel), 1);
   endtask

   // high half: wait for end, then confirm idle
   task automatic run_high_to_idle();
      int edges = 0;
      while (count != 0 && edges < 400) begin
         @(negedge clk);
         edges++;
      end
      repeat (6) begin
         @(negedge clk);
         chk(count == 0 && scl_rel == 1'b1, "R8 idle after high half", int'(count), 0);
      end
   endtask

   task automatic t_reset();
      chk(count == 0, "R1 count", int'(count), 0);
      chk(tc == 1'b1, "R1 tc", int'(tc), 1);
      chk(scl_rel == 1'b1, "R1 released", int'(scl_rel), 1);
   endtask

   task automatic t_plain(input int n);
      pulse_load(n);
      run_low(n);
      @(negedge clk);
      chk(count == 0, "R6 no early reload (1)", int'(count), 0);
      @(negedge clk);
      chk(count == 0, "R6 no early reload (2)", int'(count), 0);
      @(negedge clk);
      chk(count == W'(n), "R6 reload on line high", int'(count), n);
      run_high_to_idle();
   endtask

   task automatic t_stretch();
      @(negedge clk);
      slave_hold = 1'b1;
      pulse_load(3);
      run_low(3);
      repeat (10) begin
         @(negedge clk);
         chk(count == 0 && tc == 1'b1, "R5 hold while stretched", int'(count), 0);
      end
      slave_hold = 1'b0;
      @(negedge clk);
      chk(count == 0, "R6 stretch latency (1)", int'(count), 0);
      @(negedge clk);
      chk(count == 0, "R6 stretch latency (2)", int'(count), 0);
      @(negedge clk);
      chk(count == 3, "R6 reload after stretch", int'(count), 3);
      @(negedge clk);
      @(negedge clk);
      chk(count == 2, "R6 counting resumes", int'(count), 2);
      run_high_to_idle();
   endtask

   task automatic t_zero();
      pulse_load(0);
      chk(count == 0 && tc == 1'b1, "R7 zero reload tc", int'(count), 0);
      chk(scl_rel == 1'b0, "R7 zero reload drives low", int'(scl_rel), 0);
      @(negedge clk);
      chk(scl_rel == 1'b1, "R7 zero reload release", int'(scl_rel), 1);
      repeat (12) begin
         @(negedge clk);
         chk(count == 0, "R7 no wrap", int'(count), 0);
      end
      chk(scl_rel == 1'b1, "R8 stays released", int'(scl_rel), 1);
   endtask

   task automatic t_midchange();
      int prev;
      pulse_load(6);
      repeat (2) @(negedge clk);
      prev = int'(count);
      reload_val = W'(100);
      @(negedge clk);
      chk(int'(count) <= prev && int'(count) >= prev - 1, "R9 running count kept",
          int'(count), prev);
      while (count != 0) @(negedge clk);
      @(negedge clk);
      repeat (3) @(negedge clk);
      chk(count == 100, "R9 new value at reload", int'(count), 100);
      run_high_to_idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_plain(3);
      t_plain(5);
      t_plain(1);
      t_plain(127);
      t_stretch();
      t_zero();
      t_midchange();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule